// File: doc/BRIEF.md
# Filtered Event Counter Slice

This block is one counting lane of a performance-monitoring unit. Each cycle it can take an increment from the event source it is attached to. It adds that amount to a 64-bit count when three things hold: the lane is enabled, the privilege filter in its type register lets the current exception level and security state through, and no count discard is pending. When the sum passes the all-ones value of the active width (32 or 64 bits, picked by an input), the count wraps and an overflow pulse lasting one cycle is sent to the interrupt logic outside the block.

Software can load the count, clear it, and rewrite the type register, which holds the filter bits and the event number. After a load or a clear, the next accepted increment is dropped and not added. If the lane's event number equals the software-increment event, the hardware amount is ignored. The lane then counts only strobes whose data bit at the lane's index is set. A parameter turns the lane into the dedicated cycle-counter variant, whose event number is fixed and cannot be written.

Top module: `evt_counter_slice`

## Requirements
- R1: After reset the count is 0, the overflow output is low, and the type readback shows zero filter bits with the event field [15:0] equal to the reset event number (RST_EVT). A count discard is pending after reset.
- R2: An accepted increment adds incAmt to the count. The new value appears on cntVal in the cycle after the clock edge that captured it.
- R3: With mode64 low, the low 32 bits wrap when amount plus low word exceeds 0xFFFFFFFF. The upper 32 bits hold, and ovfPulse is high for exactly one cycle with the wrapped value. Reaching exactly 0xFFFFFFFF gives no pulse.
- R4: With mode64 high, overflow and wrap happen at the 64-bit boundary instead. A carry out of the low word then goes into the upper word with no pulse.
- R5: At exception level 0 (excLvl=0), counting is blocked when type bit 30 is set in the secure state, or when bit 30 differs from bit 28 in the non-secure state.
- R6: At exception level 1, counting is blocked when type bit 31 is set in the secure state, or when bit 31 differs from bit 29 in the non-secure state.
- R7: At exception level 2, counting is blocked when type bit 27 is clear. At exception level 3, it is blocked when bit 31 differs from bit 26. Neither case depends on the security state.
- R8: After a value load or a clear, the next accepted increment is discarded. Blocked or disabled cycles do not use up the discard.
- R9: In one cycle, a clear (zeroReq) wins over a value load (wrValEn), and both win over an increment.
- R10: When the event field equals SW_EVT, incAmt is ignored. A software strobe adds 1 only when countEn is high and swIncData bit CNT_IDX is 1.
- R11: The type readback returns the written bits [31:16] with the current event number in bits [15:0].
- R12: In the cycle-counter variant (IS_CYCLE=1), type writes update bits [31:16] only. The event field keeps RST_EVT.
- R13: cntLow always equals the low 32 bits of the count.
- R14: A cycle with countEn low, or blocked by the filter, leaves the count unchanged and ovfPulse low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| countEn | input | 1 | Lane enable / event valid |
| incAmt | input | INC_W | Hardware increment amount |
| excLvl | input | 2 | Current exception level 0..3 |
| secure | input | 1 | Secure state flag |
| mode64 | input | 1 | 1: 64-bit overflow, 0: 32-bit overflow |
| wrValEn | input | 1 | Load count from wrVal |
| wrVal | input | CNT_W | Count load value |
| zeroReq | input | 1 | Clear count to zero |
| wrTypeEn | input | 1 | Write type register |
| wrType | input | 32 | Type register write data |
| swIncStrb | input | 1 | Software increment strobe |
| swIncData | input | SWD_W | Software increment lane mask |
| cntVal | output | CNT_W | Full count |
| cntLow | output | CNT_W/2 | Low 32-bit view |
| typeRd | output | 32 | Type register readback |
| ovfPulse | output | 1 | One-cycle overflow indication |

## Verification
The bench builds two copies. The first is an ordinary event lane at index 3, with an 8-bit increment and software event 0. Small increments and loads close to the wrap points let it reach both overflow boundaries in a few cycles. It also sweeps all 64 filter patterns over every exception level and security state. The second copy has IS_CYCLE=1 and reset event 0x11 and shares the same stimulus, which shows that its event field cannot be written.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int TYPE_W = 32;
  localparam int EVT_W  = 16;

  // Filter bit positions within the type register
  localparam int B_EXCL1 = 31;
  localparam int B_EXCL0 = 30;
  localparam int B_NS1   = 29;
  localparam int B_NS0   = 28;
  localparam int B_HYP   = 27;
  localparam int B_MON   = 26;

  typedef struct packed {
    logic exclEl1;
    logic exclEl0;
    logic nsEl1;
    logic nsEl0;
    logic inclEl2;
    logic monEl3;
  } filtFlags_t;

  typedef struct packed {
    logic clearVal;
    logic loadVal;
    logic addEn;
    logic loadType;
  } ctrlStrobes_t;
endpackage

// File: rtl/evcnt_ctrl.sv
module evcnt_ctrl
  import evcnt_pkg::*;
#(
  parameter int INC_W = 8,
  parameter int SWD_W = 32,
  parameter int CNT_IDX = 3,
  parameter logic [EVT_W-1:0] SW_EVT = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  input  logic [INC_W-1:0] incAmt,
  input  logic [1:0]       excLvl,
  input  logic             secure,
  input  logic             wrValEn,
  input  logic             zeroReq,
  input  logic             wrTypeEn,
  input  logic             swIncStrb,
  input  logic [SWD_W-1:0] swIncData,
  input  filtFlags_t       filt,
  input  logic [EVT_W-1:0] evtNum,
  output ctrlStrobes_t     st,
  output logic [INC_W-1:0] addAmt
);
  localparam logic [SWD_W-1:0] LANE_MASK = SWD_W'(1) << CNT_IDX;

  logic blocked, selSw, swHit, hit, loads, discardQ;

  always_comb begin
    unique case (excLvl)
      2'd0:    blocked = secure ? filt.exclEl0 : (filt.exclEl0 != filt.nsEl0);
      2'd1:    blocked = secure ? filt.exclEl1 : (filt.exclEl1 != filt.nsEl1);
      2'd2:    blocked = !filt.inclEl2;
      default: blocked = (filt.exclEl1 != filt.monEl3);
    endcase
  end

  assign selSw  = (evtNum == SW_EVT);
  assign swHit  = swIncStrb && ((swIncData & LANE_MASK) != '0);
  assign hit    = countEn && !blocked && (selSw ? swHit : 1'b1);
  assign loads  = zeroReq || wrValEn;
  assign addAmt = selSw ? INC_W'(1) : incAmt;

  always_ff @(posedge clk) begin
    if (!rstN)      discardQ <= 1'b1;
    else if (loads) discardQ <= 1'b1;
    else if (hit)   discardQ <= 1'b0;
  end

  always_comb begin
    st.clearVal = zeroReq;
    st.loadVal  = wrValEn && !zeroReq;
    st.addEn    = hit && !loads && !discardQ;
    st.loadType = wrTypeEn;
  end

  // R10: a software-event add needs the lane's strobe bit
  p_sw_lane_r10: assert property (@(posedge clk) disable iff (!rstN)
    (st.addEn && selSw) |-> (swIncStrb && swIncData[CNT_IDX]));
  // R8: the first candidate increment after a load is dropped
  p_discard_r8: assert property (@(posedge clk) disable iff (!rstN)
    loads |=> !st.addEn);
endmodule

// File: rtl/evcnt_dp.sv
module evcnt_dp
  import evcnt_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int INC_W = 8,
  parameter bit IS_CYCLE = 1'b0,
  parameter logic [EVT_W-1:0] RST_EVT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      st,
  input  logic [INC_W-1:0]  addAmt,
  input  logic              mode64,
  input  logic [CNT_W-1:0]  wrVal,
  input  logic [TYPE_W-1:0] wrType,
  output logic [CNT_W-1:0]  cntVal,
  output logic [TYPE_W-1:0] typeRd,
  output filtFlags_t        filt,
  output logic [EVT_W-1:0]  evtNum,
  output logic              ovfPulse
);
  localparam int LO_W = CNT_W / 2;
  localparam int HI_W = CNT_W - LO_W;
  localparam int FL_W = TYPE_W - EVT_W;

  logic [LO_W:0]      loSum;
  logic [HI_W:0]      hiSum;
  logic [CNT_W-1:0]   cntQ, cntNext;
  logic               carry;
  logic [FL_W-1:0]    filtQ;
  logic [EVT_W-1:0]   evtQ, evtNext;

  always_comb begin
    loSum = {1'b0, cntQ[LO_W-1:0]} + (LO_W+1)'(addAmt);
    hiSum = {1'b0, cntQ[CNT_W-1:LO_W]} + (HI_W+1)'(loSum[LO_W]);
    if (mode64) begin
      cntNext = {hiSum[HI_W-1:0], loSum[LO_W-1:0]};
      carry   = hiSum[HI_W];
    end else begin
      cntNext = {cntQ[CNT_W-1:LO_W], loSum[LO_W-1:0]};
      carry   = loSum[LO_W];
    end
  end

  // Cycle-counter variant keeps its event number on type writes
  assign evtNext = IS_CYCLE ? evtQ : wrType[EVT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ     <= '0;
      ovfPulse <= 1'b0;
      filtQ    <= '0;
      evtQ     <= RST_EVT;
    end else begin
      ovfPulse <= 1'b0;
      if (st.clearVal)     cntQ <= '0;
      else if (st.loadVal) cntQ <= wrVal;
      else if (st.addEn) begin
        cntQ     <= cntNext;
        ovfPulse <= carry;
      end
      if (st.loadType) begin
        filtQ <= wrType[TYPE_W-1:EVT_W];
        evtQ  <= evtNext;
      end
    end
  end

  assign cntVal       = cntQ;
  assign evtNum       = evtQ;
  assign typeRd       = {filtQ, evtQ};
  assign filt.exclEl1 = filtQ[B_EXCL1-EVT_W];
  assign filt.exclEl0 = filtQ[B_EXCL0-EVT_W];
  assign filt.nsEl1   = filtQ[B_NS1-EVT_W];
  assign filt.nsEl0   = filtQ[B_NS0-EVT_W];
  assign filt.inclEl2 = filtQ[B_HYP-EVT_W];
  assign filt.monEl3  = filtQ[B_MON-EVT_W];

  // R9: a clear lands as zero next cycle
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.clearVal |=> (cntVal == '0));
  // R9: a load lands the written value
  p_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.loadVal |=> (cntVal == $past(wrVal)));
  // R14: no strobe, no change and no overflow
  p_hold_r14: assert property (@(posedge clk) disable iff (!rstN)
    !(st.addEn || st.loadVal || st.clearVal) |=> ($stable(cntVal) && !ovfPulse));
  // R3: a 32-bit overflow wraps the low word downward and keeps the upper word
  p_wrap32_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ovfPulse && !$past(mode64)) |->
      ((cntVal[LO_W-1:0] < $past(cntVal[LO_W-1:0])) &&
       (cntVal[CNT_W-1:LO_W] == $past(cntVal[CNT_W-1:LO_W]))));
endmodule

// File: rtl/evt_counter_slice.sv
module evt_counter_slice
  import evcnt_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int INC_W = 8,
  parameter int SWD_W = 32,
  parameter int CNT_IDX = 3,
  parameter bit IS_CYCLE = 1'b0,
  parameter logic [EVT_W-1:0] RST_EVT = '0,
  parameter logic [EVT_W-1:0] SW_EVT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              countEn,
  input  logic [INC_W-1:0]  incAmt,
  input  logic [1:0]        excLvl,
  input  logic              secure,
  input  logic              mode64,
  input  logic              wrValEn,
  input  logic [CNT_W-1:0]  wrVal,
  input  logic              zeroReq,
  input  logic              wrTypeEn,
  input  logic [TYPE_W-1:0] wrType,
  input  logic              swIncStrb,
  input  logic [SWD_W-1:0]  swIncData,
  output logic [CNT_W-1:0]  cntVal,
  output logic [CNT_W/2-1:0] cntLow,
  output logic [TYPE_W-1:0] typeRd,
  output logic              ovfPulse
);
  ctrlStrobes_t     st;
  filtFlags_t       filt;
  logic [EVT_W-1:0] evtNum;
  logic [INC_W-1:0] addAmt;

  evcnt_ctrl #(.INC_W(INC_W), .SWD_W(SWD_W), .CNT_IDX(CNT_IDX), .SW_EVT(SW_EVT)) u_ctrl (
    .clk(clk), .rstN(rstN), .countEn(countEn), .incAmt(incAmt), .excLvl(excLvl),
    .secure(secure), .wrValEn(wrValEn), .zeroReq(zeroReq), .wrTypeEn(wrTypeEn),
    .swIncStrb(swIncStrb), .swIncData(swIncData), .filt(filt), .evtNum(evtNum),
    .st(st), .addAmt(addAmt));

  evcnt_dp #(.CNT_W(CNT_W), .INC_W(INC_W), .IS_CYCLE(IS_CYCLE), .RST_EVT(RST_EVT)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .addAmt(addAmt), .mode64(mode64), .wrVal(wrVal),
    .wrType(wrType), .cntVal(cntVal), .typeRd(typeRd), .filt(filt), .evtNum(evtNum),
    .ovfPulse(ovfPulse));

  assign cntLow = cntVal[CNT_W/2-1:0];
endmodule

// File: tb/tb_evt_counter_slice.sv
module tb_evt_counter_slice;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        countEn = 0, secure = 0, mode64 = 0, wrValEn = 0, zeroReq = 0;
  logic        wrTypeEn = 0, swIncStrb = 0;
  logic [7:0]  incAmt = 0;
  logic [1:0]  excLvl = 0;
  logic [63:0] wrVal = 0;
  logic [31:0] wrType = 0, swIncData = 0;
  logic [63:0] cntVal, cntValC;
  logic [31:0] cntLow, cntLowC, typeRd, typeRdC;
  logic        ovfPulse, ovfPulseC;

  int checks = 0, fails = 0, cycles = 0;
  logic [63:0] expVal;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_counter_slice dut (
    .clk(clk), .rstN(rstN), .countEn(countEn), .incAmt(incAmt), .excLvl(excLvl),
    .secure(secure), .mode64(mode64), .wrValEn(wrValEn), .wrVal(wrVal), .zeroReq(zeroReq),
    .wrTypeEn(wrTypeEn), .wrType(wrType), .swIncStrb(swIncStrb), .swIncData(swIncData),
    .cntVal(cntVal), .cntLow(cntLow), .typeRd(typeRd), .ovfPulse(ovfPulse));

  evt_counter_slice #(.IS_CYCLE(1'b1), .RST_EVT(16'h0011)) dutCyc (
    .clk(clk), .rstN(rstN), .countEn(countEn), .incAmt(incAmt), .excLvl(excLvl),
    .secure(secure), .mode64(mode64), .wrValEn(wrValEn), .wrVal(wrVal), .zeroReq(zeroReq),
    .wrTypeEn(wrTypeEn), .wrType(wrType), .swIncStrb(swIncStrb), .swIncData(swIncData),
    .cntVal(cntValC), .cntLow(cntLowC), .typeRd(typeRdC), .ovfPulse(ovfPulseC));

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      summary();
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic setType(logic [31:0] t);
    wrTypeEn = 1; wrType = t; tick(); wrTypeEn = 0;
  endtask
  task automatic loadVal(logic [63:0] v);
    wrValEn = 1; wrVal = v; tick(); wrValEn = 0;
  endtask
  task automatic clearVal();
    zeroReq = 1; tick(); zeroReq = 0;
  endtask
  task automatic inc(logic [7:0] a);
    countEn = 1; incAmt = a; tick(); countEn = 0; incAmt = 0;
  endtask

  function automatic bit blockedModel(int el, bit sec, logic [5:0] pat);
    // pat: [5]=bit31 [4]=bit30 [3]=bit29 [2]=bit28 [1]=bit27 [0]=bit26
    case (el)
      0: return sec ? pat[4] : (pat[4] != pat[2]);
      1: return sec ? pat[5] : (pat[5] != pat[3]);
      2: return !pat[1];
      default: return pat[5] != pat[0];
    endcase
  endfunction

  // R1
  task automatic t_reset();
    chk("R1 count", cntVal, 64'd0);
    chk("R1 ovf", {63'd0, ovfPulse}, 64'd0);
    chk("R1 type", {32'd0, typeRd}, 64'd0);
    chk("R1 cycle type", {32'd0, typeRdC}, 64'h11);
  endtask

  // R2, R8 (reset-armed discard)
  task automatic t_basic();
    excLvl = 2; secure = 0; mode64 = 1;
    setType(32'h0800_0005);
    inc(8'd7);
    chk("R8 discard after reset", cntVal, 64'd0);
    inc(8'd7);
    chk("R2 add", cntVal, 64'd7);
    inc(8'd3);
    chk("R2 add", cntVal, 64'd10);
    chk("R13 low view", {32'd0, cntLow}, 64'd10);
  endtask

  // R8, R14
  task automatic t_discard();
    loadVal(64'h100);
    chk("R9 load", cntVal, 64'h100);
    inc(8'd4);
    chk("R8 discard after load", cntVal, 64'h100);
    inc(8'd4);
    chk("R8 resume", cntVal, 64'h104);
    clearVal();
    setType(32'h0000_0005); // EL2 now blocked
    inc(8'd9);
    chk("R14 blocked hold", cntVal, 64'd0);
    chk("R14 blocked no ovf", {63'd0, ovfPulse}, 64'd0);
    countEn = 0; incAmt = 8'd9; tick(); incAmt = 0;
    chk("R14 disabled hold", cntVal, 64'd0);
    setType(32'h0800_0005);
    inc(8'd2);
    chk("R8 blocked did not consume", cntVal, 64'd0);
    inc(8'd2);
    chk("R8 then counts", cntVal, 64'd2);
  endtask

  // R9
  task automatic t_priority();
    wrValEn = 1; wrVal = 64'h50; countEn = 1; incAmt = 8'd9; tick();
    wrValEn = 0; countEn = 0; incAmt = 0;
    chk("R9 load beats inc", cntVal, 64'h50);
    zeroReq = 1; wrValEn = 1; wrVal = 64'h77; tick();
    zeroReq = 0; wrValEn = 0;
    chk("R9 clear beats load", cntVal, 64'd0);
    inc(8'd5);
    chk("R9 discard armed", cntVal, 64'd0);
  endtask

  // R3, R13
  task automatic t_ovf32();
    mode64 = 0;
    loadVal(64'h0000_0000_FFFF_FFF0);
    inc(8'd1);
    inc(8'h0F);
    chk("R3 reach all-ones", cntVal, 64'h0000_0000_FFFF_FFFF);
    chk("R3 no pulse at all-ones", {63'd0, ovfPulse}, 64'd0);
    inc(8'd1);
    chk("R3 wrap to zero", cntVal, 64'd0);
    chk("R3 pulse", {63'd0, ovfPulse}, 64'd1);
    loadVal(64'h0000_0001_FFFF_FFFE);
    inc(8'd1);
    inc(8'd5);
    chk("R3 upper held", cntVal, 64'h0000_0001_0000_0003);
    chk("R13 low view", {32'd0, cntLow}, 64'd3);
    chk("R3 pulse", {63'd0, ovfPulse}, 64'd1);
    tick();
    chk("R3 pulse one cycle", {63'd0, ovfPulse}, 64'd0);
  endtask

  // R4
  task automatic t_ovf64();
    mode64 = 1;
    loadVal(64'h0000_0000_FFFF_FFFF);
    inc(8'd1);
    inc(8'd2);
    chk("R4 carry into upper", cntVal, 64'h0000_0001_0000_0001);
    chk("R4 no pulse at 32", {63'd0, ovfPulse}, 64'd0);
    loadVal(64'hFFFF_FFFF_FFFF_FFFE);
    inc(8'd1);
    inc(8'd3);
    chk("R4 wrap 64", cntVal, 64'd1);
    chk("R4 pulse", {63'd0, ovfPulse}, 64'd1);
    tick();
    chk("R4 pulse one cycle", {63'd0, ovfPulse}, 64'd0);
  endtask

  // R5, R6, R7
  task automatic t_filter_sweep();
    mode64 = 1; excLvl = 2; secure = 0;
    setType(32'h0800_0005);
    clearVal();
    inc(8'd1);
    expVal = 64'd0;
    for (int el = 0; el < 4; el++) begin
      for (int s = 0; s < 2; s++) begin
        for (int p = 0; p < 64; p++) begin
          logic [5:0] pat;
          bit blk;
          pat = 6'(p);
          setType({pat, 10'd0, 16'd5});
          excLvl = 2'(el); secure = 1'(s);
          blk = blockedModel(el, 1'(s), pat);
          inc(8'd1);
          if (!blk) expVal = expVal + 64'd1;
          if (el == 0)      chk("R5 EL0 filter", cntVal, expVal);
          else if (el == 1) chk("R6 EL1 filter", cntVal, expVal);
          else              chk("R7 EL2/EL3 filter", cntVal, expVal);
        end
      end
    end
    excLvl = 2; secure = 0;
  endtask

  // R10
  task automatic t_swinc();
    setType(32'h0800_0000);
    expVal = cntVal;
    countEn = 1; swIncStrb = 1; swIncData = 32'h0000_0008; tick();
    countEn = 0; swIncStrb = 0; swIncData = 0;
    chk("R10 sw add", cntVal, expVal + 64'd1);
    countEn = 1; swIncStrb = 1; swIncData = 32'hFFFF_FFF7; tick();
    countEn = 0; swIncStrb = 0; swIncData = 0;
    chk("R10 other lanes ignored", cntVal, expVal + 64'd1);
    countEn = 0; swIncStrb = 1; swIncData = 32'h0000_0008; tick();
    swIncStrb = 0; swIncData = 0;
    chk("R10 needs enable", cntVal, expVal + 64'd1);
    inc(8'd50);
    chk("R10 amount ignored", cntVal, expVal + 64'd1);
  endtask

  // R11, R12
  task automatic t_type();
    setType(32'hABCD_1234);
    chk("R11 readback", {32'd0, typeRd}, 64'hABCD_1234);
    chk("R12 cycle event fixed", {32'd0, typeRdC}, 64'hABCD_0011);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1;
    t_reset();
    t_basic();
    t_discard();
    t_priority();
    t_ovf32();
    t_ovf64();
    t_filter_sweep();
    t_swinc();
    t_type();
    summary();
  end
endmodule